// File: doc/BRIEF.md
# Text Console Pixel Generator

This block turns a running raster position into pixel colours for a 160 by 45 character text console on a 1280×720 display. It runs on the single pixel clock and needs no faster clock. Each cycle it takes the horizontal and vertical pixel counters and the two syncs and blank from a video timing generator. It reads a cell memory holding a character code and a colour attribute, then a glyph memory holding one 8-pixel row per character and scanline. The result is a 24-bit colour plus a delayed copy of the syncs and blank.

The syncs and blank leave the block exactly eight cycles after they enter. The colour for a given position leaves in that same cycle. The counters therefore act as a lookahead: the cell and glyph reads for a position begin eight pixels before it is shown. The glyph row of a cell is latched into a shift register when its first pixel comes due, and the eight bits are then shifted out while the next cell's row is already in flight. Both memories are external synchronous-read block RAMs with one cycle of read latency.

Top module: `text_console_gen`

## Requirements
- R1: `hsync_o`, `vsync_o` and `blank_o` equal `hsync_i`, `vsync_i` and `blank_i` as sampled eight clock edges earlier.
- R2: One edge after a position is sampled, `cell_addr_o` equals (pix_y_i / 16) × 160 + (pix_x_i / 8).
- R3: Two edges after `cell_addr_o` is presented, `font_addr_o` equals {cell_data_i[7:0], pix_y_i[3:0]} of that position. The character code sits in bits 7:0 of the cell word.
- R4: The glyph row is loaded when the position's x modulo 8 is zero. Pixel x of a cell shows bit (7 − x mod 8) of the row, so the MSB comes out first.
- R5: A set glyph bit selects the foreground index in cell bits 11:8. A clear bit selects the background index in cell bits 15:12.
- R6: Index i maps to rgb_o = {R,G,B}, with R from bit 2, G from bit 1 and B from bit 0. A channel whose bit is set is 0xFF if i[3] is set and 0xAA otherwise. A channel whose bit is clear is 0x55 if i[3] is set and 0x00 otherwise.
- R7: Whenever `blank_o` is high, `rgb_o` is zero.
- R8: While `rst_n` is low, all registered outputs clear to zero at each clock edge.
- R9: The colour for a position appears on `rgb_o` in the same cycle as that position's delayed syncs and blank, eight edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x_i | input | 11 | Horizontal pixel counter (lookahead position) |
| pix_y_i | input | 10 | Vertical line counter (lookahead position) |
| hsync_i | input | 1 | Horizontal sync from the timing generator |
| vsync_i | input | 1 | Vertical sync from the timing generator |
| blank_i | input | 1 | High outside the visible area |
| cell_addr_o | output | 13 | Read address into the cell memory |
| cell_data_i | input | 16 | Cell word: bg index, fg index, character code |
| font_addr_o | output | 12 | Read address into the glyph memory |
| font_data_i | input | 8 | Glyph row, MSB is the leftmost pixel |
| rgb_o | output | 24 | Pixel colour {R,G,B} |
| hsync_o | output | 1 | Horizontal sync, delayed 8 cycles |
| vsync_o | output | 1 | Vertical sync, delayed 8 cycles |
| blank_o | output | 1 | Blank, delayed 8 cycles |

## Verification
The assertions assume four things about the inputs. Each memory returns data for the address it was given on the previous edge. The counters stay inside the 1280×720 raster when the cell-range property applies. Within a line, x advances by one per cycle from a multiple of 8, so every shown pixel was preceded by the load of its own cell row. The stimulus respects this by driving runs that start at a random cell-aligned column, last a whole number of cells and never cross the right edge, with random sync and blank levels on every pixel. Directed runs hit the top-left and bottom-right cells and a fully blanked stretch.

// File: rtl/txt_con_pkg.sv
// Package: shared types and the 16-entry colour map for the text console.
// Assumes 8-bit colour channels and 4-bit colour indices.
package txt_con_pkg;

    typedef struct packed {
        logic hs;
        logic vs;
        logic blank;
    } vtiming_t;

    localparam int IDX_W = 4;
    localparam int RGB_W = 24;

    // Expand one channel: the bright bit picks the high pair of levels.
    function automatic logic [7:0] chan_level(input logic on, input logic bright);
        logic [7:0] lvl;
        if (on) lvl = bright ? 8'hFF : 8'hAA;
        else    lvl = bright ? 8'h55 : 8'h00;
        return lvl;
    endfunction

    // Map a colour index to {R,G,B}.
    function automatic logic [RGB_W-1:0] idx_to_rgb(input logic [IDX_W-1:0] idx);
        return {chan_level(idx[2], idx[3]),
                chan_level(idx[1], idx[3]),
                chan_level(idx[0], idx[3])};
    endfunction

endpackage

// File: rtl/vtiming_delay.sv
// Delay line for sync and blank.
// Tap k of the output array holds the input delayed k+1 cycles.
// Assumes DEPTH >= 1.
module vtiming_delay
    import txt_con_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  vtiming_t tim_i,
    output vtiming_t taps_o [DEPTH]
);

    vtiming_t stage_q [DEPTH];

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_stage
            if (k == 0) begin : g_head
                // Capture the incoming timing word.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= tim_i;
                end
            end else begin : g_body
                // Move the word one stage down the line.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[k] <= '0;
                    else        stage_q[k] <= stage_q[k-1];
                end
            end
            assign taps_o[k] = stage_q[k];
        end
    endgenerate

endmodule

// File: rtl/cell_fetch.sv
// Address pipeline: turns a raster position into a cell address,
// then into a glyph address once the cell word returns.
// The attribute and the in-cell x offset are aligned with the glyph row.
// Assumes both memories have one cycle of synchronous read latency.
module cell_fetch #(
    parameter int X_W     = 11,
    parameter int Y_W     = 10,
    parameter int COLS    = 160,
    parameter int ROWS    = 45,
    parameter int GLYPH_W = 8,
    parameter int GLYPH_H = 16,
    parameter int CODE_W  = 8,
    parameter int ATTR_W  = 8,
    parameter int CELL_AW = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [X_W-1:0]                x_i,
    input  logic [Y_W-1:0]                y_i,
    output logic [CELL_AW-1:0]            cell_addr_o,
    input  logic [CODE_W+ATTR_W-1:0]      cell_data_i,
    output logic [CODE_W+$clog2(GLYPH_H)-1:0] font_addr_o,
    output logic [ATTR_W-1:0]             attr_o,
    output logic [$clog2(GLYPH_W)-1:0]    xoff_o
);

    localparam int GX_W  = $clog2(GLYPH_W);
    localparam int GY_W  = $clog2(GLYPH_H);
    localparam int CELLS = COLS * ROWS;

    logic [X_W-GX_W-1:0] col;
    logic [Y_W-GY_W-1:0] row;
    logic [GX_W-1:0]     xoff1_q, xoff2_q, xoff3_q, xoff4_q;
    logic [GY_W-1:0]     yrow1_q, yrow2_q;
    logic [ATTR_W-1:0]   attr3_q, attr4_q;

    assign col = x_i[X_W-1:GX_W];
    assign row = y_i[Y_W-1:GY_W];

    // Stage 1: register the cell address and the in-cell offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_addr_o <= '0;
            xoff1_q     <= '0;
            yrow1_q     <= '0;
        end else begin
            cell_addr_o <= CELL_AW'(int'(row) * COLS + int'(col));
            xoff1_q     <= x_i[GX_W-1:0];
            yrow1_q     <= y_i[GY_W-1:0];
        end
    end

    // Stage 2: wait while the cell memory reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff2_q <= '0;
            yrow2_q <= '0;
        end else begin
            xoff2_q <= xoff1_q;
            yrow2_q <= yrow1_q;
        end
    end

    // Stage 3: form the glyph address and keep the attribute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            font_addr_o <= '0;
            attr3_q     <= '0;
            xoff3_q     <= '0;
        end else begin
            font_addr_o <= {cell_data_i[CODE_W-1:0], yrow2_q};
            attr3_q     <= cell_data_i[CODE_W+ATTR_W-1:CODE_W];
            xoff3_q     <= xoff2_q;
        end
    end

    // Stage 4: wait while the glyph memory reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr4_q <= '0;
            xoff4_q <= '0;
        end else begin
            attr4_q <= attr3_q;
            xoff4_q <= xoff3_q;
        end
    end

    assign attr_o = attr4_q;
    assign xoff_o = xoff4_q;

    // R2: a position inside the raster yields an address inside the cell array.
    p_cell_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(x_i) < COLS * GLYPH_W && int'(y_i) < ROWS * GLYPH_H)
        |=> (int'(cell_addr_o) < CELLS));

endmodule

// File: rtl/glyph_shifter.sv
// Glyph row shift register with its cell attribute.
// At the first pixel of a cell it loads the fetched row and attribute.
// Otherwise it shifts left, so the MSB is always the current pixel.
// Assumes x steps by one per cycle from a cell boundary.
module glyph_shifter #(
    parameter int GLYPH_W = 8,
    parameter int ATTR_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [GLYPH_W-1:0]         row_i,
    input  logic [ATTR_W-1:0]          attr_i,
    input  logic [$clog2(GLYPH_W)-1:0] xoff_i,
    output logic                       pix_on_o,
    output logic [ATTR_W/2-1:0]        fg_o,
    output logic [ATTR_W/2-1:0]        bg_o
);

    localparam int HALF = ATTR_W / 2;

    logic [GLYPH_W-1:0] bits_q;
    logic [ATTR_W-1:0]  attr_q;
    logic               load;

    assign load = (xoff_i == '0);

    // Load at a cell boundary, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            attr_q <= '0;
        end else if (load) begin
            bits_q <= row_i;
            attr_q <= attr_i;
        end else begin
            bits_q <= {bits_q[GLYPH_W-2:0], 1'b0};
        end
    end

    assign pix_on_o = bits_q[GLYPH_W-1];
    assign fg_o     = attr_q[HALF-1:0];
    assign bg_o     = attr_q[ATTR_W-1:HALF];

    // R5: the attribute is stable over the pixels of one cell.
    p_attr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(attr_q));

endmodule

// File: rtl/colour_out.sv
// Colour stage: maps the pixel bit to the foreground or background colour,
// forces black during blanking, then pads to the total latency.
// Assumes STAGES >= 1.
module colour_out
    import txt_con_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_on_i,
    input  logic [IDX_W-1:0] fg_i,
    input  logic [IDX_W-1:0] bg_i,
    input  logic             dark_i,
    output logic [RGB_W-1:0] rgb_o
);

    logic [RGB_W-1:0] pipe_q [STAGES];
    logic [RGB_W-1:0] shade;

    // Select the index and expand it, unless the pixel is blanked.
    always_comb begin
        if (dark_i) shade = '0;
        else        shade = idx_to_rgb(pix_on_i ? fg_i : bg_i);
    end

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_pad
            if (k == 0) begin : g_first
                // Register the computed colour.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[0] <= '0;
                    else        pipe_q[0] <= shade;
                end
            end else begin : g_rest
                // Carry the colour toward the output.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[k] <= '0;
                    else        pipe_q[k] <= pipe_q[k-1];
                end
            end
        end
    endgenerate

    assign rgb_o = pipe_q[STAGES-1];

endmodule

// File: rtl/text_console_gen.sv
// Text console pixel generator, top level.
// The sync and blank delay of LOOKAHEAD cycles matches the internal path:
// 4 cycles of address and memory pipeline, 1 shift register and
// LOOKAHEAD-5 colour registers.
// Assumes LOOKAHEAD >= 6 and memories with one cycle of read latency.
module text_console_gen
    import txt_con_pkg::*;
#(
    parameter int X_W       = 11,
    parameter int Y_W       = 10,
    parameter int COLS      = 160,
    parameter int ROWS      = 45,
    parameter int GLYPH_W   = 8,
    parameter int GLYPH_H   = 16,
    parameter int CODE_W    = 8,
    parameter int LOOKAHEAD = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [X_W-1:0]                      pix_x_i,
    input  logic [Y_W-1:0]                      pix_y_i,
    input  logic                                hsync_i,
    input  logic                                vsync_i,
    input  logic                                blank_i,
    output logic [$clog2(COLS*ROWS)-1:0]        cell_addr_o,
    input  logic [CODE_W+2*4-1:0]               cell_data_i,
    output logic [CODE_W+$clog2(GLYPH_H)-1:0]   font_addr_o,
    input  logic [GLYPH_W-1:0]                  font_data_i,
    output logic [23:0]                         rgb_o,
    output logic                                hsync_o,
    output logic                                vsync_o,
    output logic                                blank_o
);

    localparam int CELL_AW    = $clog2(COLS * ROWS);
    localparam int GX_W       = $clog2(GLYPH_W);
    localparam int GY_W       = $clog2(GLYPH_H);
    localparam int ATTR_W     = 2 * IDX_W;
    localparam int FETCH_LAT  = 4;
    localparam int SHIFT_TAP  = FETCH_LAT;
    localparam int OUT_STAGES = LOOKAHEAD - FETCH_LAT - 1;

    vtiming_t          tim_in;
    vtiming_t          taps [LOOKAHEAD];
    logic [ATTR_W-1:0] attr_al;
    logic [GX_W-1:0]   xoff_al;
    logic              pix_on;
    logic [IDX_W-1:0]  fg_idx, bg_idx;

    assign tim_in = '{hs: hsync_i, vs: vsync_i, blank: blank_i};

    vtiming_delay #(.DEPTH(LOOKAHEAD)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .tim_i  (tim_in),
        .taps_o (taps)
    );

    cell_fetch #(
        .X_W     (X_W),
        .Y_W     (Y_W),
        .COLS    (COLS),
        .ROWS    (ROWS),
        .GLYPH_W (GLYPH_W),
        .GLYPH_H (GLYPH_H),
        .CODE_W  (CODE_W),
        .ATTR_W  (ATTR_W),
        .CELL_AW (CELL_AW)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .x_i         (pix_x_i),
        .y_i         (pix_y_i),
        .cell_addr_o (cell_addr_o),
        .cell_data_i (cell_data_i),
        .font_addr_o (font_addr_o),
        .attr_o      (attr_al),
        .xoff_o      (xoff_al)
    );

    glyph_shifter #(
        .GLYPH_W (GLYPH_W),
        .ATTR_W  (ATTR_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_i    (font_data_i),
        .attr_i   (attr_al),
        .xoff_i   (xoff_al),
        .pix_on_o (pix_on),
        .fg_o     (fg_idx),
        .bg_o     (bg_idx)
    );

    colour_out #(.STAGES(OUT_STAGES)) u_colour (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_on_i (pix_on),
        .fg_i     (fg_idx),
        .bg_i     (bg_idx),
        .dark_i   (taps[SHIFT_TAP].blank),
        .rgb_o    (rgb_o)
    );

    assign hsync_o = taps[LOOKAHEAD-1].hs;
    assign vsync_o = taps[LOOKAHEAD-1].vs;
    assign blank_o = taps[LOOKAHEAD-1].blank;

    // R7: the delayed blank and the colour path agree on dark pixels.
    p_blank_is_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> (rgb_o == '0));

    // R3: the glyph address carries the code returned on the previous edge.
    p_font_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (font_addr_o[CODE_W+GY_W-1:GY_W] == $past(cell_data_i[CODE_W-1:0])));

    // R8: leaving reset, the outputs still hold their cleared values.
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rgb_o == '0 && !hsync_o && !vsync_o && !blank_o && cell_addr_o == '0));

endmodule

// File: tb/text_console_gen_test.sv
module text_console_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] pix_x = '0;
    logic [9:0]  pix_y = '0;
    logic        hs_in = 1'b0, vs_in = 1'b0, bl_in = 1'b0;
    logic [12:0] cell_addr;
    logic [15:0] cell_data;
    logic [11:0] font_addr;
    logic [7:0]  font_data;
    logic [23:0] rgb;
    logic        hs_out, vs_out, bl_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // History of driven inputs; index 0 is the most recent.
    logic [10:0] hx [8];
    logic [9:0]  hy [8];
    logic        hh [8], hv [8], hb [8], hval [8];

    always #2 clk = ~clk;

    text_console_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_x_i     (pix_x),
        .pix_y_i     (pix_y),
        .hsync_i     (hs_in),
        .vsync_i     (vs_in),
        .blank_i     (bl_in),
        .cell_addr_o (cell_addr),
        .cell_data_i (cell_data),
        .font_addr_o (font_addr),
        .font_data_i (font_data),
        .rgb_o       (rgb),
        .hsync_o     (hs_out),
        .vsync_o     (vs_out),
        .blank_o     (bl_out)
    );

    // Memory contents are computed, not stored.
    function automatic logic [15:0] cell_word(input int a);
        int v;
        v = a * 40503 + 12345;
        return 16'(v ^ (a >> 2) ^ (a << 7));
    endfunction

    function automatic logic [7:0] font_row(input int a);
        int v;
        v = a * 37 + 90;
        return 8'(v ^ (a >> 3) * 11);
    endfunction

    // Synchronous-read memories, one cycle latency.
    always @(posedge clk) begin
        cell_data <= cell_word(int'(cell_addr));
        font_data <= font_row(int'(font_addr));
    end

    function automatic logic [23:0] ref_colour(input logic [3:0] i);
        logic [7:0] hi, lo;
        hi = i[3] ? 8'hFF : 8'hAA;
        lo = i[3] ? 8'h55 : 8'h00;
        return {(i[2] ? hi : lo), (i[1] ? hi : lo), (i[0] ? hi : lo)};
    endfunction

    function automatic int ref_cell(input logic [10:0] x, input logic [9:0] y);
        return int'(y / 16) * 160 + int'(x / 8);
    endfunction

    function automatic logic [23:0] ref_pixel(input logic [10:0] x, input logic [9:0] y,
                                              input logic blank);
        logic [15:0] cw;
        logic [7:0]  row;
        if (blank) return 24'h0;
        cw  = cell_word(ref_cell(x, y));
        row = font_row(int'({cw[7:0], y[3:0]}));
        return row[7 - int'(x[2:0])] ? ref_colour(cw[11:8]) : ref_colour(cw[15:12]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One pixel: check the outputs of earlier pixels, then drive the next.
    task automatic step(input logic [10:0] x, input logic [9:0] y, input logic bl);
        logic [11:0] exp_fa;
        @(negedge clk);
        if (hval[0])
            check(cell_addr == 13'(ref_cell(hx[0], hy[0])), "R2 cell address",
                  32'(cell_addr), 32'(ref_cell(hx[0], hy[0])));
        if (hval[2]) begin
            exp_fa = {cell_word(ref_cell(hx[2], hy[2]))[7:0], hy[2][3:0]};
            check(font_addr == exp_fa, "R3 font address", 32'(font_addr), 32'(exp_fa));
        end
        if (hval[7]) begin
            check({hs_out, vs_out, bl_out} == {hh[7], hv[7], hb[7]}, "R1 timing delay",
                  32'({hs_out, vs_out, bl_out}), 32'({hh[7], hv[7], hb[7]}));
            if (hb[7])
                check(rgb == 24'h0, "R7 blank colour", 32'(rgb), 32'h0);
            else
                check(rgb == ref_pixel(hx[7], hy[7], 1'b0), "R4 R5 R6 R9 pixel colour",
                      32'(rgb), 32'(ref_pixel(hx[7], hy[7], 1'b0)));
        end
        for (int k = 7; k > 0; k--) begin
            hx[k] = hx[k-1]; hy[k] = hy[k-1]; hh[k] = hh[k-1];
            hv[k] = hv[k-1]; hb[k] = hb[k-1]; hval[k] = hval[k-1];
        end
        pix_x = x; pix_y = y; bl_in = bl;
        hs_in = 1'($urandom_range(0, 1));
        vs_in = 1'($urandom_range(0, 1));
        hx[0] = x; hy[0] = y; hh[0] = hs_in; hv[0] = vs_in; hb[0] = bl; hval[0] = 1'b1;
    endtask

    // A run of whole cells starting at a cell boundary on one line.
    task automatic run_cells(input int col0, input int y, input int ncells, input int blank_mode);
        for (int c = 0; c < ncells; c++)
            for (int p = 0; p < 8; p++) begin
                logic b;
                b = (blank_mode == 1) ? 1'b1 :
                    (blank_mode == 2) ? 1'($urandom_range(0, 3) == 0) : 1'b0;
                step(11'((col0 + c) * 8 + p), 10'(y), b);
            end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        for (int k = 0; k < 8; k++) begin
            hval[k] = 1'b0; hx[k] = '0; hy[k] = '0; hh[k] = 0; hv[k] = 0; hb[k] = 0;
        end
        pix_x = 11'd345; pix_y = 10'd222; hs_in = 1'b1; vs_in = 1'b1; bl_in = 1'b1;
        repeat (4) @(negedge clk);
        // R8: registered outputs cleared while reset is held.
        check(rgb == 24'h0 && !hs_out && !vs_out && !bl_out, "R8 reset outputs",
              32'({rgb, hs_out, vs_out, bl_out}), 32'h0);
        check(cell_addr == 13'h0 && font_addr == 12'h0, "R8 reset addresses",
              32'({cell_addr, font_addr}), 32'h0);
        rst_n = 1'b1;
        // Directed corners: top-left, bottom-right, a blanked run, a line edge.
        run_cells(0, 0, 3, 0);
        run_cells(157, 719, 3, 0);
        run_cells(40, 100, 4, 1);
        run_cells(150, 15, 10, 0);
        run_cells(0, 16, 160, 2);
        // Random runs.
        for (int r = 0; r < 300; r++) begin
            int col0, len, y;
            col0 = $urandom_range(0, 159);
            len  = $urandom_range(1, 8);
            if (col0 + len > 160) len = 160 - col0;
            y = $urandom_range(0, 719);
            run_cells(col0, y, len, 2);
        end
        // Flush the pipeline.
        for (int k = 0; k < 9; k++) step(11'd0, 10'd0, 1'b1);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule